// File: doc/BRIEF.md
# Rotating-Pointer Victim Selector with Fully Associative Tag Store

This block holds a small fully associative tag store and picks which entry to overwrite on the next allocation. It has no index field. Every entry has its own comparator, so a lookup checks all stored tags in parallel. The comparison is combinational: a lookup gives a hit flag and the matching entry number in the same cycle.

Replacement uses one rotating pointer that names the current victim. The pointer moves forward by one only when the entry it names is touched, either by a lookup hit or by being written on an allocation. Touching any other entry leaves the pointer where it is. The result is a not-most-recently-used policy: the entry just used is never the next victim.

A two-state controller tracks whether the store still has empty entries.
- In `ST_FILL`, allocations go to the lowest-numbered invalid entry.
- The transition `FILL_DONE` moves the controller to `ST_FULL` when the last invalid entry is written.
- In `ST_FULL`, allocations overwrite the entry the pointer names. The transition `HOLD_FULL` keeps the controller there until reset.

Top module: `nmru_tag_store`

## Requirements
- R1: After reset, `victim_o` is 0 and every entry is invalid.
- R2: A lookup hits in the same cycle only if a valid entry holds a tag equal to `lookup_tag_i`. In that case `hit_idx_o` gives that entry's number.
- R3: An invalid entry never hits. This holds even when its stored tag (0 after reset) equals the lookup tag.
- R4: While invalid entries remain (`ST_FILL`), an allocation writes the lowest-numbered invalid entry. From reset the store therefore fills entries 0, 1, 2 and so on, in that order.
- R5: A lookup hit on the entry that the pointer names advances the pointer by one.
- R6: A lookup hit on any other entry leaves the pointer unchanged.
- R7: Once all entries are valid (`ST_FULL`), an allocation overwrites the entry the pointer names and then advances the pointer. The overwritten tag no longer hits, and the new tag hits at that entry.
- R8: A pointer advance from entry ENTRIES-1 wraps to entry 0.
- R9: When a hit on the pointer entry and an allocation into that same entry happen in one cycle, the pointer advances by exactly one.
- R10: `victim_o` is registered. It shows the pointer value after the update made at the previous clock edge.
- R11: The controller leaves `ST_FILL` (transition `FILL_DONE`) when the last invalid entry is allocated. It then stays in `ST_FULL` (transition `HOLD_FULL`) until reset, so later allocations follow the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid_i | input | 1 | A lookup is presented this cycle |
| lookup_tag_i | input | TAG_W | Tag to search for |
| hit_o | output | 1 | Lookup matched a valid entry |
| hit_idx_o | output | IDX_W | Number of the matching entry |
| alloc_valid_i | input | 1 | Allocate a new tag this cycle |
| alloc_tag_i | input | TAG_W | Tag to write on allocation |
| victim_o | output | IDX_W | Registered replacement pointer |

## Verification
The assertions assume three things about the inputs:
- An allocation only brings in a tag that is not already stored.
- The allocated tag never equals a lookup tag presented in the same cycle.
- As a result, at most one entry can match a lookup.

The bench keeps within these assumptions by the way it builds tags. Allocation tags come from a counter that only increases and stays below 0x8000. Tags meant to miss are drawn from the upper half of the tag space. Tags meant to hit are copied from entries the bench model marks as valid.

// File: rtl/nmru_pkg.sv
package nmru_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/nmru_tag_array.sv
module nmru_tag_array #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lookup_valid_i,
    input  logic [TAG_W-1:0]   lookup_tag_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [TAG_W-1:0]   wr_tag_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   hit_idx_o,
    output logic [ENTRIES-1:0] valid_o
);
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
        end else if (wr_en_i) begin
            valid_q[wr_idx_i] <= 1'b1;
            tag_q[wr_idx_i]   <= wr_tag_i;
        end
    end

    // one comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = lookup_valid_i && valid_q[g] && (tag_q[g] == lookup_tag_i);
    end

    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx_o = IDX_W'(i);
        end
    end

    assign hit_o   = |match;
    assign valid_o = valid_q;

    // R2
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R3
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> valid_q[hit_idx_o]);
endmodule

// File: rtl/nmru_free_find.sv
module nmru_free_find #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    output logic               any_free_o,
    output logic               one_free_o,
    output logic [IDX_W-1:0]   free_idx_o
);
    logic [ENTRIES-1:0] empty;

    assign empty      = ~valid_i;
    assign any_free_o = |empty;
    assign one_free_o = any_free_o && ((empty & (empty - 1'b1)) == '0);

    always_comb begin
        free_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (empty[i]) free_idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/nmru_ptr_ctrl.sv
module nmru_ptr_ctrl
    import nmru_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] hit_idx_i,
    input  logic             alloc_i,
    input  logic [IDX_W-1:0] free_idx_i,
    input  logic             one_free_i,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [IDX_W-1:0] victim_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    fill_state_e      state_q, state_d;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_inc;
    logic             touch;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (alloc_i && one_free_i) state_d = ST_FULL; // FILL_DONE
            ST_FULL: state_d = ST_FULL;                             // HOLD_FULL
        endcase
    end

    always_comb begin
        wr_idx_o = ptr_q;
        unique case (state_q)
            ST_FILL: wr_idx_o = free_idx_i;
            ST_FULL: wr_idx_o = ptr_q;
        endcase
    end

    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign touch   = (hit_i && (hit_idx_i == ptr_q)) || (alloc_i && (wr_idx_o == ptr_q));

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (touch) ptr_q <= ptr_inc;
    end

    assign victim_o = ptr_q;

    // R4
    fill_tracks_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (free_idx_i == ptr_q));

    // R5
    hit_ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && hit_idx_i == ptr_q && ptr_q != LAST) |=> (ptr_q == IDX_W'($past(ptr_q) + 1'b1)));

    // R6
    other_hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_i && !(hit_i && hit_idx_i == ptr_q)) |=> $stable(victim_o));

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && wr_idx_o == LAST && ptr_q == LAST) |=> (ptr_q == '0));

    // R11
    stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |=> (state_q == ST_FULL));
endmodule

// File: rtl/nmru_tag_store.sv
module nmru_tag_store #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lookup_valid_i,
    input  logic [TAG_W-1:0] lookup_tag_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] hit_idx_o,
    input  logic             alloc_valid_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    output logic [IDX_W-1:0] victim_o
);
    logic [ENTRIES-1:0] valid_vec;
    logic               any_free, one_free;
    logic [IDX_W-1:0]   free_idx, wr_idx;

    nmru_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_array (
        .clk           (clk),
        .rst_n         (rst_n),
        .lookup_valid_i(lookup_valid_i),
        .lookup_tag_i  (lookup_tag_i),
        .wr_en_i       (alloc_valid_i),
        .wr_idx_i      (wr_idx),
        .wr_tag_i      (alloc_tag_i),
        .hit_o         (hit_o),
        .hit_idx_o     (hit_idx_o),
        .valid_o       (valid_vec)
    );

    nmru_free_find #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_free (
        .valid_i   (valid_vec),
        .any_free_o(any_free),
        .one_free_o(one_free),
        .free_idx_o(free_idx)
    );

    nmru_ptr_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit_o),
        .hit_idx_i (hit_idx_o),
        .alloc_i   (alloc_valid_i),
        .free_idx_i(free_idx),
        .one_free_i(one_free),
        .wr_idx_o  (wr_idx),
        .victim_o  (victim_o)
    );

    // R1
    reset_victim_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (victim_o == '0));

    // R7
    full_alloc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && !any_free) |-> (wr_idx == victim_o));
endmodule

// File: tb/nmru_tag_store_tb_top.sv
module nmru_tag_store_tb_top;
    localparam int N  = 64;
    localparam int TW = 16;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lookup_valid_i = 1'b0;
    logic [TW-1:0] lookup_tag_i = '0;
    logic          hit_o;
    logic [IW-1:0] hit_idx_o;
    logic          alloc_valid_i = 1'b0;
    logic [TW-1:0] alloc_tag_i = '0;
    logic [IW-1:0] victim_o;

    always #5 clk = ~clk;

    nmru_tag_store #(.ENTRIES(N), .TAG_W(TW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid_i(lookup_valid_i), .lookup_tag_i(lookup_tag_i),
        .hit_o(hit_o), .hit_idx_o(hit_idx_o),
        .alloc_valid_i(alloc_valid_i), .alloc_tag_i(alloc_tag_i),
        .victim_o(victim_o)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [TW-1:0] m_tag [N];
    bit          m_valid [N];
    int          m_ptr = 0;
    int          serial = 1;

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_lookup(logic [TW-1:0] t);
        int idx = -1;
        for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == t) idx = i;
        return idx;
    endfunction

    function automatic int model_target();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        return m_ptr;
    endfunction

    task automatic cycle(string req, bit lv, logic [TW-1:0] lt, bit av, logic [TW-1:0] at);
        int eidx;
        int tgt;
        bit adv;
        @(negedge clk);
        lookup_valid_i = lv; lookup_tag_i = lt;
        alloc_valid_i = av;  alloc_tag_i = at;
        #1;
        eidx = lv ? model_lookup(lt) : -1;
        chk(req, int'(hit_o), (eidx >= 0) ? 1 : 0);
        if (eidx >= 0) chk(req, int'(hit_idx_o), eidx);
        chk("R10", int'(victim_o), m_ptr);
        @(posedge clk);
        tgt = model_target();
        adv = (eidx == m_ptr) || av;
        if (av) begin
            m_valid[tgt] = 1;
            m_tag[tgt]   = at;
        end
        if (adv) m_ptr = (m_ptr + 1) % N;
        #1;
        lookup_valid_i = 0; alloc_valid_i = 0;
    endtask

    task automatic vchk(string req, int exp);
        @(negedge clk); #1;
        chk(req, int'(victim_o), exp);
    endtask

    task automatic alloc_new(string req);
        cycle(req, 0, '0, 1, TW'(serial));
        serial++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_tag[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R3 invalid entry with tag 0 does not hit
        vchk("R1", 0);
        cycle("R3", 1, 16'h0000, 0, '0);

        // R4 fill in ascending order
        alloc_new("R4"); vchk("R4", 1);
        alloc_new("R4"); vchk("R4", 2);
        alloc_new("R4"); vchk("R4", 3);
        cycle("R4", 1, 16'd3, 0, '0);
        // R6 hit away from pointer
        cycle("R2", 1, 16'd2, 0, '0); vchk("R6", 3);
        cycle("R2", 1, 16'h9000, 0, '0);

        // R11 fill the rest, pointer wraps by allocation (R8)
        for (int k = 3; k < N; k++) alloc_new("R11");
        vchk("R8", 0);
        // R5 hit at pointer advances
        cycle("R5", 1, 16'd1, 0, '0); vchk("R5", 1);
        cycle("R6", 1, 16'd6, 0, '0); vchk("R6", 1);

        // R9 same-cycle hit on pointer entry and allocation into it
        cycle("R9", 1, 16'd2, 1, TW'(serial)); serial++;
        vchk("R9", 2);
        // R7 old tag gone, new tag at entry 1
        cycle("R7", 1, 16'd2, 0, '0);
        chk("R7", int'(hit_o), 0);
        cycle("R7", 1, TW'(serial - 1), 0, '0);
        chk("R7", int'(hit_idx_o), 1);
        // R7 allocation in full store goes to pointer
        alloc_new("R7"); vchk("R7", 3);
        cycle("R7", 1, 16'd3, 0, '0);
        chk("R7", int'(hit_o), 0);

        // R8 walk pointer to last entry by hits, then wrap
        while (m_ptr != N - 1) cycle("R5", 1, m_tag[m_ptr], 0, '0);
        vchk("R8", N - 1);
        cycle("R8", 1, m_tag[N-1], 0, '0);
        vchk("R8", 0);

        // random mix
        for (int it = 0; it < 3000; it++) begin
            int r = int'($urandom % 5);
            int e = int'($urandom % N);
            if (r == 0)      cycle("R5", 1, m_tag[m_ptr], 0, '0);
            else if (r == 1) cycle("R6", 1, m_tag[e], 0, '0);
            else if (r == 2) cycle("R2", 1, TW'(16'h8000 | ($urandom & 16'h7fff)), 0, '0);
            else if (r == 3) begin
                cycle("R9", 1, m_tag[e], 1, TW'(serial)); serial++;
            end else alloc_new("R7");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule